// File: doc/BRIEF.md
# PCI Configuration Status Word

This block keeps the 16-bit status word of a PCI configuration header for a device that acts as both target and bus master. The bus interface gives it single-cycle event pulses: a detected parity error, a signaled system error, a received master abort, a received target abort, a signaled target abort, and a PERR that this device drove or saw on the bus. Each pulse sets its own sticky flag. The data-parity flag is different. It sets only when the PERR event comes while this device owns the transfer as master and the parity-response enable from the command register is on.

A configuration read returns the assembled word on `rd_data`. The word holds the sticky flags, a fixed DEVSEL timing code, and two capability bits that follow configuration straps. A configuration write can only clear flags: writing 1 to a sticky bit in an enabled byte clears it. A write never sets a bit. When an event and a clear hit the same flag in the same clock, the event wins.

Top module: `pci_cfg_status`

## Requirements
- R1: After reset every sticky flag (bits 15, 14, 13, 12, 11, 8) reads 0.
- R2: A parity-detect pulse sets bit 15 on the next clock, whatever the value of the parity-response enable.
- R3: Pulses for system error signaled, master abort received, target abort received and target abort signaled set bits 14, 13, 12 and 11 respectively on the next clock. Each flag stays set until it is cleared.
- R4: A write with `wr_be[1]`=1 clears each sticky bit whose data bit is 1. Sticky bits whose data bit is 0 keep their value.
- R5: A write never sets any bit. Writing all ones to a word whose flags are all clear leaves it unchanged.
- R6: Bits 10:9 always read 01b, the code for medium DEVSEL timing (DEVSEL two clocks after FRAME).
- R7: Bit 8 sets on the clock after a PERR event only if `master_act` and `perr_resp_en` are both 1 in that cycle. Otherwise bit 8 stays 0.
- R8: Bit 7 reads `strap_fbb` and bit 4 reads `strap_pm`. Writes to bits 7 and 4 have no effect.
- R9: Bits 6, 5 and 3:0 always read 0, and writes to them are ignored.
- R10: If a set event and a write-1-to-clear reach the same flag in one cycle, the flag reads 1 afterwards.
- R11: A write with `wr_be[1]`=0 clears no bit. All sticky bits lie in the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset |
| ev_par_det | input | 1 | Parity error detected pulse |
| ev_serr_sig | input | 1 | System error signaled pulse |
| ev_mabort_rcv | input | 1 | Master abort received pulse |
| ev_tabort_rcv | input | 1 | Target abort received pulse |
| ev_tabort_sig | input | 1 | Target abort signaled pulse |
| ev_perr_seen | input | 1 | PERR driven or observed pulse |
| master_act | input | 1 | Device is master of the current transfer |
| perr_resp_en | input | 1 | Parity-response enable from the command word |
| strap_fbb | input | 1 | Fast back-to-back capable strap |
| strap_pm | input | 1 | Power-management (capability list) strap |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data, ones mark bits to clear |
| rd_data | output | 16 | Assembled status word |

## Verification
An event pulse and a configuration write that clears the same flag can land in the same clock. The bench provokes this by raising a master-abort pulse in the very cycle it writes 1 to bit 13, with bit 12 also set and cleared by that write. It expects bit 13 to stay set and bit 12 to drop. The bench also repeats the data-parity test with each of its three qualifiers removed in turn, and confirms that a write with the upper byte disabled leaves the flags untouched.

// File: rtl/pci_cfg_status.sv
module pci_cfg_status #(
  parameter logic [1:0] DEVSEL_CODE = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_par_det,
  input  logic        ev_serr_sig,
  input  logic        ev_mabort_rcv,
  input  logic        ev_tabort_rcv,
  input  logic        ev_tabort_sig,
  input  logic        ev_perr_seen,
  input  logic        master_act,
  input  logic        perr_resp_en,
  input  logic        strap_fbb,
  input  logic        strap_pm,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);

  // flag order: [5]=b15 [4]=b14 [3]=b13 [2]=b12 [1]=b11 [0]=b8
  logic [5:0] flag_q;
  logic [5:0] set_v;
  logic [5:0] clr_v;
  logic       dpar_hit;

  assign dpar_hit = ev_perr_seen & master_act & perr_resp_en;
  assign set_v    = {ev_par_det, ev_serr_sig, ev_mabort_rcv,
                     ev_tabort_rcv, ev_tabort_sig, dpar_hit};
  assign clr_v    = (wr_en && wr_be[1]) ? {wr_data[15:11], wr_data[8]} : 6'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_v | (flag_q & ~clr_v);
  end

  assign rd_data = {flag_q[5:1], DEVSEL_CODE, flag_q[0],
                    strap_fbb, 2'b00, strap_pm, 4'b0000};

  // R2
  par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par_det |=> rd_data[15]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mabort_rcv && wr_en && wr_be[1] && wr_data[13]) |=> rd_data[13]);

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[14] && !ev_serr_sig) |=> !rd_data[14]);

  // R11
  be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[12] && !(wr_en && wr_be[1])) |=> rd_data[12]);

  // R7
  dpar_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[8] && !(ev_perr_seen && master_act && perr_resp_en)) |=> !rd_data[8]);

  // R5
  no_wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[11] && !ev_tabort_sig) |=> !rd_data[11]);

endmodule

// File: tb/sim_pci_cfg_status.sv
module sim_pci_cfg_status;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  ev = '0;
  logic        master_act = 0, perr_resp_en = 0, strap_fbb = 0, strap_pm = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pci_cfg_status u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_par_det(ev[5]), .ev_serr_sig(ev[4]), .ev_mabort_rcv(ev[3]),
    .ev_tabort_rcv(ev[2]), .ev_tabort_sig(ev[1]), .ev_perr_seen(ev[0]),
    .master_act(master_act), .perr_resp_en(perr_resp_en),
    .strap_fbb(strap_fbb), .strap_pm(strap_pm),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data));

  task automatic check(input logic [15:0] exp, input string tag);
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  task automatic cycle(input logic [5:0] e, input logic w, input logic [1:0] be,
                       input logic [15:0] d);
    @(negedge clk);
    ev = e; wr_en = w; wr_be = be; wr_data = d;
    @(negedge clk);
    ev = '0; wr_en = 0; wr_be = '0; wr_data = '0;
  endtask

  task automatic t_reset();
    check(16'h0200, "R1 R6 R9 reset word");
  endtask

  task automatic t_parity();
    perr_resp_en = 0;
    cycle(6'b100000, 0, 2'b00, 16'h0);
    check(16'h8200, "R2 parity flag with response off");
    cycle(6'b000000, 1, 2'b10, 16'h8000);
    check(16'h0200, "R4 clear bit 15");
  endtask

  task automatic t_sticky();
    for (int i = 1; i <= 4; i++) begin
      logic [15:0] m;
      m = 16'h0800 << (i - 1);
      cycle(6'b000001 << i, 0, 2'b00, 16'h0);
      cycle(6'b0, 0, 2'b00, 16'h0);
      check(16'h0200 | m, "R3 sticky flag held");
      cycle(6'b0, 1, 2'b10, m);
      check(16'h0200, "R4 sticky flag cleared");
    end
  endtask

  task automatic t_dpar();
    master_act = 0; perr_resp_en = 0;
    cycle(6'b000001, 0, 2'b00, 16'h0);
    check(16'h0200, "R7 no master no enable");
    master_act = 1; perr_resp_en = 0;
    cycle(6'b000001, 0, 2'b00, 16'h0);
    check(16'h0200, "R7 enable off");
    master_act = 0; perr_resp_en = 1;
    cycle(6'b000001, 0, 2'b00, 16'h0);
    check(16'h0200, "R7 not master");
    master_act = 1; perr_resp_en = 1;
    cycle(6'b000000, 0, 2'b00, 16'h0);
    check(16'h0200, "R7 no perr event");
    cycle(6'b000001, 0, 2'b00, 16'h0);
    check(16'h0300, "R7 all three hold");
    cycle(6'b0, 1, 2'b10, 16'h0100);
    check(16'h0200, "R4 clear bit 8");
    master_act = 0; perr_resp_en = 0;
  endtask

  task automatic t_noset();
    cycle(6'b0, 1, 2'b11, 16'hFFFF);
    check(16'h0200, "R5 R9 all-ones write sets nothing");
  endtask

  task automatic t_straps();
    strap_fbb = 1;
    check(16'h0280, "R8 fast back-to-back strap");
    strap_pm = 1;
    check(16'h0290, "R8 capability strap");
    cycle(6'b0, 1, 2'b11, 16'h0000);
    check(16'h0290, "R8 zero write no effect");
    cycle(6'b0, 1, 2'b11, 16'hFFFF);
    check(16'h0290, "R8 ones write no effect");
    strap_fbb = 0;
    check(16'h0210, "R8 strap follows");
    strap_pm = 0;
  endtask

  task automatic t_setwins();
    cycle(6'b001100, 0, 2'b00, 16'h0);
    check(16'h3200, "R3 two flags set");
    cycle(6'b001000, 1, 2'b10, 16'h3000);
    check(16'h2200, "R10 event beats clear");
    cycle(6'b0, 1, 2'b10, 16'h2000);
    check(16'h0200, "R4 later clear");
  endtask

  task automatic t_bytes();
    cycle(6'b010000, 0, 2'b00, 16'h0);
    cycle(6'b0, 1, 2'b01, 16'hFFFF);
    check(16'h4200, "R11 low byte only");
    cycle(6'b0, 1, 2'b00, 16'hFFFF);
    check(16'h4200, "R11 no byte enabled");
    cycle(6'b0, 1, 2'b11, 16'h0000);
    check(16'h4200, "R4 zero data keeps flag");
    cycle(6'b0, 1, 2'b10, 16'h4000);
    check(16'h0200, "R11 upper byte clears");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_parity();
    t_sticky();
    t_dpar();
    t_noset();
    t_straps();
    t_setwins();
    t_bytes();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule